// File: doc/BRIEF.md
# Transactional Commit Write Buffer

This block holds every store issued by one speculative transaction in a private buffer that sits beside the data cache, never reaching shared memory while the transaction runs. Each buffer entry pairs a line tag with its data. A second store to a tag already held replaces that entry's data, so each line appears once. When the owner signals the end of the transaction, the block asks a system arbiter for commit permission and waits.

Once the grant arrives, the buffered writes leave as one unbroken packet on a broadcast stream. The packet has one beat per held line, in the order the lines were first written. A start marker sits on the first beat and an end marker on the last. A mode input, sampled at transaction end, selects whether beats carry data (for update-style snooping) or addresses only (for invalidate-style snooping). An abort discards the whole buffer at once. A store of a new line into a full buffer is refused and flagged.

Top module: `txn_commit_buffer`

## Requirements
- R1: While a transaction is collecting stores, `req` and `pkt_valid` stay 0; no store is visible on the packet stream.
- R2: A store whose address matches a held entry overwrites that entry's data; the packet then carries a single beat for that address with the most recent data.
- R3: Distinct addresses are kept in first-store order, and the packet's beats follow that order.
- R4: A `txn_end` pulse with a non-empty buffer raises `req` in the next cycle. No beat appears before a grant. `grant` is honoured only while `req` is 1. The first beat appears two cycles after the clock edge that samples `grant` high.
- R5: The packet has one beat per held entry, on consecutive cycles. `pkt_sop` is 1 only on the first beat and `pkt_eop` only on the last; a one-entry packet has both set on its only beat.
- R6: `with_data` is sampled in the `txn_end` cycle. If it was 1, `pkt_data` carries the stored data; if it was 0, `pkt_data` is 0 on every beat. Later changes of `with_data` have no effect on a pending packet.
- R7: `req` stays 1 through the final beat and is 0 in the cycle after it, together with `pkt_valid`. The buffer is then empty and `overflow` is 0.
- R8: When all DEPTH entries are in use, a store to a new address is not accepted and `overflow` reads 1 from the next cycle until an abort or a completed commit. A store to a held address while full is still accepted as an overwrite.
- R9: An `abort` while collecting or while waiting for a grant empties the buffer in one cycle, drops `req` and clears `overflow`. A store in the same cycle as the abort is discarded.
- R10: An `abort` while the packet is being sent has no effect: every beat of the packet is delivered.
- R11: `txn_end` with an empty buffer raises no request. Stores presented while a request is pending or a packet is being sent are ignored.
- R12: After reset, `req`, `pkt_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store strobe |
| st_addr | input | ADDR_W | Line tag of the store |
| st_data | input | DATA_W | Store data |
| txn_end | input | 1 | Pulse: the transaction is complete, request commit |
| with_data | input | 1 | Packet mode at `txn_end`: 1 address plus data, 0 address only |
| abort | input | 1 | Pulse: discard the buffered writes |
| grant | input | 1 | Commit permission from the arbiter |
| req | output | 1 | Commit request to the arbiter |
| pkt_valid | output | 1 | Packet beat valid |
| pkt_sop | output | 1 | First beat of the packet |
| pkt_eop | output | 1 | Last beat of the packet |
| pkt_addr | output | ADDR_W | Beat address |
| pkt_data | output | DATA_W | Beat data, 0 in address-only mode |
| overflow | output | 1 | A new-line store was refused because the buffer was full |

## Verification
Three patterns of distinct addresses separate ordering faults from count faults: three lines, one line, and a completely full buffer. An interleaved repeat of one address shows that a hit overwrites in place and does not append. A full buffer followed by one new-line store and one repeated-address store shows the refusal path apart from the overwrite path. Aborts are placed in each phase (collecting, waiting for a grant, mid-packet). Stores are placed while a request is pending, and a grant is given with no request pending; together these show which states accept inputs and which ignore them.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_REQ     = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_FIN     = 2'd3
  } tcb_state_e;
endpackage

// File: rtl/tcb_tag_cam.sv
// Line-tag store with parallel match and an indexed read for the drain.
module tcb_tag_cam #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic [CNT_W-1:0]  fill,
  input  logic              wr_new,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] rd_tag
);
  logic [ADDR_W-1:0] tags [DEPTH];
  logic [DEPTH-1:0]  match;

  always_ff @(posedge clk) begin
    if (wr_new) tags[wr_idx] <= lookup_addr;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(i);
    assign match[i] = (SLOT < fill) && (tags[i] == lookup_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit    = |match;
  assign rd_tag = tags[rd_idx];
endmodule

// File: rtl/tcb_data_ram.sv
// Simple dual-port store data memory, registered read.
module tcb_data_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_sequencer.sv
// Collect / request / drain control and the registered packet framing.
module tcb_sequencer
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic              txn_end,
  input  logic              with_data,
  input  logic              abort,
  input  logic              grant,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [ADDR_W-1:0] rd_tag,
  output logic [CNT_W-1:0]  fill,
  output logic              wr_en,
  output logic              wr_new,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              req,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic              mode_q,
  output logic              overflow
);
  tcb_state_e state;
  logic full, take, refuse, last_beat;

  assign full      = (fill == CNT_W'(DEPTH));
  assign take      = st_valid && (state == ST_COLLECT) && !abort;
  assign wr_en     = take && (hit || !full);
  assign wr_new    = take && !hit && !full;
  assign refuse    = take && !hit && full;
  assign wr_idx    = hit ? hit_idx : fill[IDX_W-1:0];
  assign last_beat = (CNT_W'(rd_idx) == (fill - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      fill      <= '0;
      req       <= 1'b0;
      overflow  <= 1'b0;
      mode_q    <= 1'b0;
      rd_idx    <= '0;
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
      pkt_addr  <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (abort) begin
            fill     <= '0;
            overflow <= 1'b0;
          end else begin
            if (wr_new) fill <= fill + CNT_W'(1);
            if (refuse) overflow <= 1'b1;
            if (txn_end && ((fill != '0) || wr_new)) begin
              state  <= ST_REQ;
              req    <= 1'b1;
              mode_q <= with_data;
            end
          end
        end
        ST_REQ: begin
          if (abort) begin
            state    <= ST_COLLECT;
            req      <= 1'b0;
            fill     <= '0;
            overflow <= 1'b0;
          end else if (grant) begin
            state  <= ST_DRAIN;
            rd_idx <= '0;
          end
        end
        ST_DRAIN: begin
          pkt_valid <= 1'b1;
          pkt_sop   <= (rd_idx == '0);
          pkt_eop   <= last_beat;
          pkt_addr  <= rd_tag;
          rd_idx    <= rd_idx + IDX_W'(1);
          if (last_beat) state <= ST_FIN;
        end
        default: begin
          pkt_valid <= 1'b0;
          pkt_sop   <= 1'b0;
          pkt_eop   <= 1'b0;
          req       <= 1'b0;
          fill      <= '0;
          overflow  <= 1'b0;
          state     <= ST_COLLECT;
        end
      endcase
    end
  end
endmodule

// File: rtl/txn_commit_buffer.sv
module txn_commit_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              txn_end,
  input  logic              with_data,
  input  logic              abort,
  input  logic              grant,
  output logic              req,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0]  fill;
  logic              hit, wr_en, wr_new, mode_q;
  logic [IDX_W-1:0]  hit_idx, wr_idx, rd_idx;
  logic [ADDR_W-1:0] rd_tag;
  logic [DATA_W-1:0] ram_q;

  tcb_tag_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .lookup_addr(st_addr), .fill(fill), .wr_new(wr_new),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .hit(hit), .hit_idx(hit_idx), .rd_tag(rd_tag)
  );

  tcb_data_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(st_data),
    .raddr(rd_idx), .rdata(ram_q)
  );

  tcb_sequencer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .st_valid(st_valid), .txn_end(txn_end),
    .with_data(with_data), .abort(abort), .grant(grant), .hit(hit),
    .hit_idx(hit_idx), .rd_tag(rd_tag), .fill(fill), .wr_en(wr_en),
    .wr_new(wr_new), .wr_idx(wr_idx), .rd_idx(rd_idx), .req(req),
    .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .pkt_addr(pkt_addr), .mode_q(mode_q), .overflow(overflow)
  );

  assign pkt_data = (pkt_valid && mode_q) ? ram_q : '0;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker (
  input logic clk,
  input logic rst,
  input logic st_valid,
  input logic abort,
  input logic grant,
  input logic req,
  input logic pkt_valid,
  input logic pkt_sop,
  input logic pkt_eop,
  input logic overflow
);
  a_r5_first_beat_sop: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> pkt_sop);

  a_r5_sop_not_repeated: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && $past(pkt_valid)) |-> !pkt_sop);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_eop) |=> pkt_valid);

  a_r7_req_drops_after_end: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_eop) |=> (!req && !pkt_valid));

  a_r7_beat_under_req: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> req);

  a_r4_grant_before_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> $past(grant && req, 2));

  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(st_valid));

  a_r10_abort_in_drain: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_eop && abort) |=> pkt_valid);
endmodule

bind txn_commit_buffer tcb_checker u_tcb_checker (
  .clk(clk), .rst(rst), .st_valid(st_valid), .abort(abort), .grant(grant),
  .req(req), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
  .overflow(overflow)
);

// File: tb/txn_commit_buffer_bench.sv
`timescale 1ns/1ps
module txn_commit_buffer_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic txn_end = 1'b0, with_data = 1'b0, abort = 1'b0, grant = 1'b0;
  logic req, pkt_valid, pkt_sop, pkt_eop, overflow;
  logic [ADDR_W-1:0] pkt_addr;
  logic [DATA_W-1:0] pkt_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [ADDR_W-1:0] cap_a [64];
  logic [DATA_W-1:0] cap_d [64];
  logic              cap_s [64];
  logic              cap_e [64];
  int                cap_n;
  logic [ADDR_W-1:0] exp_a [64];
  logic [DATA_W-1:0] exp_d [64];
  int                exp_n;

  always #4 clk = ~clk;

  txn_commit_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_txn_commit_buffer (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .txn_end(txn_end), .with_data(with_data), .abort(abort), .grant(grant),
    .req(req), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
    chk(req == 1'b0 && pkt_valid == 1'b0, "R1", "no traffic while collecting",
        {req, pkt_valid}, 0);
  endtask

  task automatic pulse_abort();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  // End the transaction, grant, and capture the packet.
  task automatic do_commit(input bit md, input int abort_beat, input bit sneak);
    txn_end = 1'b1; with_data = md;
    @(negedge clk);
    txn_end = 1'b0; with_data = !md;   // R6: later mode changes are ignored
    chk(req == 1'b1, "R4", "req after end", req, 1);
    chk(pkt_valid == 1'b0, "R4", "no beat before grant", pkt_valid, 0);
    if (sneak) begin
      st_valid = 1'b1; st_addr = 16'h0061; st_data = 32'h6161;  // R11
    end
    @(negedge clk);
    st_valid = 1'b0;
    chk(pkt_valid == 1'b0 && req == 1'b1, "R4", "still waiting", {req, pkt_valid}, 2);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(pkt_valid == 1'b0, "R4", "one cycle after grant edge", pkt_valid, 0);
    @(negedge clk);
    cap_n = 0;
    while (pkt_valid == 1'b1 && cap_n < 64) begin
      cap_a[cap_n] = pkt_addr;
      cap_d[cap_n] = pkt_data;
      cap_s[cap_n] = pkt_sop;
      cap_e[cap_n] = pkt_eop;
      chk(req == 1'b1, "R7", "req held during beat", req, 1);
      abort = (cap_n == abort_beat);
      cap_n++;
      if (cap_e[cap_n-1]) break;
      @(negedge clk);
    end
    @(negedge clk);
    abort = 1'b0;
    chk(pkt_valid == 1'b0, "R7", "valid low after last beat", pkt_valid, 0);
    chk(req == 1'b0, "R7", "req low after last beat", req, 0);
    chk(overflow == 1'b0, "R7", "overflow clear after commit", overflow, 0);
  endtask

  task automatic check_packet(input string tag);
    chk(cap_n == exp_n, tag, "beat count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_a[i] == exp_a[i], tag, $sformatf("addr beat %0d", i), cap_a[i], exp_a[i]);
      chk(cap_d[i] == exp_d[i], tag, $sformatf("data beat %0d", i), cap_d[i], exp_d[i]);
      chk(cap_s[i] == (i == 0), "R5", $sformatf("sop beat %0d", i), cap_s[i], (i == 0));
      chk(cap_e[i] == (i == exp_n - 1), "R5", $sformatf("eop beat %0d", i),
          cap_e[i], (i == exp_n - 1));
    end
  endtask

  task automatic t_reset();
    chk(req == 0 && pkt_valid == 0 && overflow == 0, "R12", "reset outputs",
        {req, pkt_valid, overflow}, 0);
  endtask

  task automatic t_ordered_three();   // R3, R5, R6
    put(16'h0A10, 32'h1111_0001);
    put(16'h0A20, 32'h2222_0002);
    put(16'h0A05, 32'h3333_0003);
    do_commit(1'b1, -1, 1'b0);
    exp_n = 3;
    exp_a[0] = 16'h0A10; exp_d[0] = 32'h1111_0001;
    exp_a[1] = 16'h0A20; exp_d[1] = 32'h2222_0002;
    exp_a[2] = 16'h0A05; exp_d[2] = 32'h3333_0003;
    check_packet("R3");
  endtask

  task automatic t_overwrite();       // R2
    put(16'h0010, 32'hAAAA_0001);
    put(16'h0020, 32'hBBBB_0002);
    put(16'h0010, 32'hCCCC_0003);
    do_commit(1'b1, -1, 1'b0);
    exp_n = 2;
    exp_a[0] = 16'h0010; exp_d[0] = 32'hCCCC_0003;
    exp_a[1] = 16'h0020; exp_d[1] = 32'hBBBB_0002;
    check_packet("R2");
  endtask

  task automatic t_addr_only();       // R6, R5 single beat
    put(16'h0070, 32'hDEAD_BEEF);
    do_commit(1'b0, -1, 1'b0);
    exp_n = 1;
    exp_a[0] = 16'h0070; exp_d[0] = 32'h0;
    check_packet("R6");
  endtask

  task automatic t_overflow();        // R8
    for (int i = 0; i < DEPTH; i++) put(16'h0100 + 16'(i), 32'(i));
    chk(overflow == 1'b0, "R8", "no overflow at exactly full", overflow, 0);
    put(16'h0200, 32'h9999);
    chk(overflow == 1'b1, "R8", "overflow after refused store", overflow, 1);
    put(16'h0103, 32'hAAAA);
    chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
    do_commit(1'b1, -1, 1'b0);
    exp_n = DEPTH;
    for (int i = 0; i < DEPTH; i++) begin
      exp_a[i] = 16'h0100 + 16'(i);
      exp_d[i] = (i == 3) ? 32'hAAAA : 32'(i);
    end
    check_packet("R8");
  endtask

  task automatic t_abort_collect();   // R9
    for (int i = 0; i < DEPTH; i++) put(16'h0100 + 16'(i), 32'h50 + 32'(i));
    put(16'h0300, 32'h1);
    chk(overflow == 1'b1, "R9", "overflow before abort", overflow, 1);
    st_valid = 1'b1; st_addr = 16'h0333; st_data = 32'h3;  // dropped with abort
    pulse_abort();
    st_valid = 1'b0;
    chk(overflow == 1'b0, "R9", "overflow cleared by abort", overflow, 0);
    put(16'h0040, 32'h4444);
    put(16'h0101, 32'h5555);
    do_commit(1'b1, -1, 1'b0);
    exp_n = 2;
    exp_a[0] = 16'h0040; exp_d[0] = 32'h4444;
    exp_a[1] = 16'h0101; exp_d[1] = 32'h5555;
    check_packet("R9");
  endtask

  task automatic t_abort_request();   // R9, R11
    put(16'h0050, 32'h5);
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    chk(req == 1'b1, "R9", "req pending", req, 1);
    pulse_abort();
    chk(req == 1'b0, "R9", "req dropped by abort", req, 0);
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    chk(req == 1'b0, "R11", "empty end makes no request", req, 0);
    @(negedge clk);
    chk(req == 1'b0 && pkt_valid == 1'b0, "R11", "still idle", {req, pkt_valid}, 0);
  endtask

  task automatic t_stray_grant();     // R4
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    @(negedge clk);
    chk(pkt_valid == 1'b0 && req == 1'b0, "R4", "grant without req ignored",
        {req, pkt_valid}, 0);
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R4", "no later beat", pkt_valid, 0);
  endtask

  task automatic t_abort_drain();     // R10
    put(16'h0801, 32'h81);
    put(16'h0802, 32'h82);
    put(16'h0803, 32'h83);
    do_commit(1'b1, 1, 1'b0);
    exp_n = 3;
    exp_a[0] = 16'h0801; exp_d[0] = 32'h81;
    exp_a[1] = 16'h0802; exp_d[1] = 32'h82;
    exp_a[2] = 16'h0803; exp_d[2] = 32'h83;
    check_packet("R10");
  endtask

  task automatic t_store_while_pending(); // R11
    put(16'h0060, 32'h60);
    do_commit(1'b1, -1, 1'b1);
    exp_n = 1;
    exp_a[0] = 16'h0060; exp_d[0] = 32'h60;
    check_packet("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ordered_three();
    t_overwrite();
    t_addr_only();
    t_overflow();
    t_abort_collect();
    t_abort_request();
    t_stray_grant();
    t_abort_drain();
    t_store_while_pending();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule